// File: doc/BRIEF.md
# Asynchronous Byte-Wide ROM Read Sequencer

This block is a clocked controller that fetches single bytes from an asynchronous, read-only, byte-wide nonvolatile memory. The memory has an active-low chip select and an active-low output gate. A requester offers an address on a valid/ready handshake. The controller then drives the address and chip select together and lowers the output gate after a lead interval. It waits out the access time, samples the byte and returns it on a one-cycle valid pulse. In the same clock cycle it releases both strobes. Before the next access it keeps the memory deselected for a float interval, so the memory's output drivers have turned off before the bus is reused.

Every timing is given in nanoseconds, together with the clock period in picoseconds. Cycle counts are derived by rounding up. The chip-select-to-gate lead equals the chip-select access count minus the gate access count, and the gate access phase lasts the gate access count. After reset, the controller holds the memory deselected for a power-up interval before it accepts any request. With no request pending, it keeps chip select high, which puts the memory in standby.

Back-pressure rules: `req_ready` is high only while the controller is idle. A requester that raises `req_valid` keeps it high, with `req_addr` unchanged, until it sees `req_ready` high at a clock edge. That edge is the handshake. The response side has no ready signal. `rsp_valid` is a single-cycle pulse, and `rsp_data` must be taken in that cycle.

Top module: `nvm_rd_ctrl`

## Requirements
- R1: From reset until the PWR-th rising clock edge after reset release, where PWR = ceil(PWRUP_NS*1000/CLK_PS), `req_ready` is low and `mem_ce_n` stays high, even with `req_valid` held high. `req_ready` is high after that edge.
- R2: A request is taken only at an edge where `req_valid` and `req_ready` are both high. At that edge `mem_addr` takes `req_addr` and `mem_ce_n` falls. `mem_addr` changes at no other edge.
- R3: `mem_oe_n` is low only while `mem_ce_n` is low.
- R4: `mem_oe_n` falls LEAD = CE - OE edges after `mem_ce_n` falls. Here CE = ceil(T_CE_NS*1000/CLK_PS), OE = ceil(T_OE_NS*1000/CLK_PS), and LEAD is floored at 0.
- R5: `rsp_valid` rises LEAD+OE edges after `mem_ce_n` falls, for exactly one cycle. On that same edge both `mem_ce_n` and `mem_oe_n` go high.
- R6: `mem_addr` holds steady during every cycle in which `mem_ce_n` is low.
- R7: After the strobes rise, `mem_ce_n` stays high for at least GAP+1 cycles. GAP = max(ceil(T_FLOAT_NS*1000/CLK_PS), ceil(T_CYCLE_NS*1000/CLK_PS) - LEAD - OE - 1, 1). If a request is already waiting when the float interval ends, the next fall comes exactly GAP+1 cycles after the rise.
- R8: While no request is offered, `mem_ce_n` and `mem_oe_n` stay high and `req_ready` stays high, for any length of time.
- R9: Every response carries the byte the memory presented for the address of its own request, and responses come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken this edge |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse, `rsp_data` is valid |
| rsp_data | output | 8 | Byte read from the memory |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_ce_n | output | 1 | Chip select to the memory, active low |
| mem_oe_n | output | 1 | Output gate to the memory, active low |
| mem_dq | input | 8 | Data bus from the memory |

## Verification
Two events share one clock edge: the data sample and the release of both strobes. The memory has zero output hold, so a sample taken one edge late finds the bus already floating. The bench models the memory in whole cycles. It presents the true byte only while both strobes are low and every access time has elapsed by the coming edge. Otherwise it presents the inverted byte. An early or late sample therefore returns a wrong value across a full address sweep. A second collision comes from a request that arrives in the middle of the float interval, or one held high back to back. The bench checks that the next chip select falls exactly GAP+1 cycles after the release, never sooner.

// File: rtl/nvm_rd_pkg.sv
package nvm_rd_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_LEAD,
    ST_ACCESS,
    ST_FLOAT
  } rd_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvm_rd_timer.sv
module nvm_rd_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // an expired count stays at zero until reloaded (phase lengths, R4)
  assert_timer_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/nvm_rd_pwrup.sv
module nvm_rd_pwrup #(
  parameter int PWR_C = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwr_last
);

  localparam int PW = $clog2(PWR_C + 1);
  localparam logic [PW-1:0] LAST = PW'(PWR_C - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign pwr_last = (cnt_q == LAST);

  // once the settle time is over it never comes back (R1)
  assert_pwr_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_last |=> pwr_last);

endmodule

// File: rtl/nvm_rd_fsm.sv
module nvm_rd_fsm
  import nvm_rd_pkg::*;
#(
  parameter int LEAD_C = 7,
  parameter int ACC_C  = 7,
  parameter int GAP_C  = 5,
  parameter int CNT_W  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_last,
  input  logic req_valid,
  output logic req_ready,
  output logic ce_n,
  output logic oe_n,
  output logic launch,
  output logic capture
);

  rd_state_e        st_q, st_d;
  logic             ce_q, ce_d, oe_q, oe_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  nvm_rd_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  always_comb begin
    st_d     = st_q;
    ce_d     = ce_q;
    oe_d     = oe_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    launch   = 1'b0;
    capture  = 1'b0;
    case (st_q)
      ST_PWRUP: begin
        if (pwr_last) st_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (req_valid) begin
          launch   = 1'b1;
          ce_d     = 1'b0;
          tmr_load = 1'b1;
          if (LEAD_C > 0) begin
            st_d    = ST_LEAD;
            tmr_val = CNT_W'(LEAD_C - 1);
          end else begin
            st_d    = ST_ACCESS;
            oe_d    = 1'b0;
            tmr_val = CNT_W'(ACC_C - 1);
          end
        end
      end
      ST_LEAD: begin
        if (tmr_zero) begin
          st_d     = ST_ACCESS;
          oe_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ACC_C - 1);
        end
      end
      ST_ACCESS: begin
        if (tmr_zero) begin
          capture  = 1'b1;
          ce_d     = 1'b1;
          oe_d     = 1'b1;
          st_d     = ST_FLOAT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(GAP_C - 1);
        end
      end
      ST_FLOAT: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_PWRUP;
        ce_d = 1'b1;
        oe_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PWRUP;
      ce_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      st_q <= st_d;
      ce_q <= ce_d;
      oe_q <= oe_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign ce_n      = ce_q;
  assign oe_n      = oe_q;

  // gate never opens on a deselected part (R3)
  assert_gate_inside_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n);

  // idle means fully deselected (R8)
  assert_idle_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n));

  // a sample is only taken while both strobes are active (R5)
  assert_sample_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!ce_n && !oe_n));

endmodule

// File: rtl/nvm_rd_path.sv
module nvm_rd_path #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              capture,
  input  logic [7:0]        dq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);

  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;
  logic [7:0]        data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (launch)  addr_q <= req_addr;
      vld_q <= capture;
      if (capture) data_q <= dq;
    end
  end

  assign mem_addr  = addr_q;
  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;

  // response is a single-cycle pulse (R5)
  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/nvm_rd_ctrl.sv
module nvm_rd_ctrl
  import nvm_rd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int CLK_PS     = 5000,
  parameter int T_CE_NS    = 70,
  parameter int T_OE_NS    = 35,
  parameter int T_FLOAT_NS = 25,
  parameter int T_CYCLE_NS = 70,
  parameter int PWRUP_NS   = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [7:0]        mem_dq
);

  localparam int CE_C   = imax(ns_to_cyc(T_CE_NS, CLK_PS), 1);
  localparam int OE_C   = imax(ns_to_cyc(T_OE_NS, CLK_PS), 1);
  localparam int LEAD_C = imax(CE_C - OE_C, 0);
  localparam int ACC_C  = OE_C;
  localparam int FLT_C  = ns_to_cyc(T_FLOAT_NS, CLK_PS);
  localparam int TRC_C  = ns_to_cyc(T_CYCLE_NS, CLK_PS);
  localparam int GAP_C  = imax(imax(FLT_C, TRC_C - LEAD_C - ACC_C - 1), 1);
  localparam int PWR_C  = imax(ns_to_cyc(PWRUP_NS, CLK_PS), 1);
  localparam int CNT_W  = imax($clog2(imax(imax(LEAD_C, ACC_C), GAP_C) + 1), 1);

  logic pwr_last;
  logic launch;
  logic capture;

  nvm_rd_pwrup #(.PWR_C(PWR_C)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_last (pwr_last)
  );

  nvm_rd_fsm #(
    .LEAD_C (LEAD_C),
    .ACC_C  (ACC_C),
    .GAP_C  (GAP_C),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_last  (pwr_last),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .launch    (launch),
    .capture   (capture)
  );

  nvm_rd_path #(.ADDR_W(ADDR_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .req_addr  (req_addr),
    .capture   (capture),
    .dq        (mem_dq),
    .mem_addr  (mem_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // ---- assertion support: length of the current deselected stretch ----
  localparam int HW = $clog2(GAP_C + 3);
  logic [HW-1:0] hi_run_q;
  logic          seen_rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q   <= '0;
      seen_rsp_q <= 1'b0;
    end else begin
      if (!mem_ce_n)                    hi_run_q <= '0;
      else if (hi_run_q != {HW{1'b1}})  hi_run_q <= hi_run_q + 1'b1;
      if (rsp_valid) seen_rsp_q <= 1'b1;
    end
  end

  // address is frozen while the part is selected (R6)
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // data comes back on the edge that releases both strobes (R5)
  assert_release_on_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_ce_n && mem_oe_n && $past(!mem_oe_n)));

  // float interval honoured before reselecting (R7)
  assert_float_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && seen_rsp_q) |-> (int'(hi_run_q) >= GAP_C + 1));

endmodule

// File: tb/sim_nvm_rd_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_rd_ctrl;

  localparam int AW         = 6;
  localparam int CLK_PS     = 5000;
  localparam int T_CE_NS    = 70;
  localparam int T_OE_NS    = 35;
  localparam int T_FLOAT_NS = 25;
  localparam int T_CYCLE_NS = 70;
  localparam int PWRUP_NS   = 100000;

  // expectations from the requirement formulas
  localparam int CE_E   = (T_CE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int OE_E   = (T_OE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int LEAD_E = (CE_E > OE_E) ? CE_E - OE_E : 0;
  localparam int FLT_E  = (T_FLOAT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int TRC_E  = (T_CYCLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int GAP_A  = (FLT_E > TRC_E - LEAD_E - OE_E - 1) ? FLT_E : TRC_E - LEAD_E - OE_E - 1;
  localparam int GAP_E  = (GAP_A > 1) ? GAP_A : 1;
  localparam int PWR_E  = (PWRUP_NS * 1000 + CLK_PS - 1) / CLK_PS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [7:0]    rsp_data;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n;
  logic          mem_oe_n;
  logic [7:0]    mem_dq = 8'h00;

  always #2.5 clk = ~clk;

  nvm_rd_ctrl #(
    .ADDR_W(AW), .CLK_PS(CLK_PS), .T_CE_NS(T_CE_NS), .T_OE_NS(T_OE_NS),
    .T_FLOAT_NS(T_FLOAT_NS), .T_CYCLE_NS(T_CYCLE_NS), .PWRUP_NS(PWRUP_NS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fpat(input int a);
    return 8'((a * 29 + 90) ^ (a >> 2));
  endfunction

  // ---------------- memory model and monitor ----------------
  int            exp_addr [0:127];
  int            n_sent = 0;
  int            n_fall = 0;
  int            n_rsp  = 0;
  bit            mon_en = 0;
  bit            gap_exact = 0;
  bit            have_rise = 0;
  int            cyc = 0;
  int            fall_cyc = 0;
  int            rise_cyc = 0;
  int            ce_age = 0, oe_age = 0, addr_age = 0;
  logic          p_ce = 1'b1, p_oe = 1'b1, p_rsp = 1'b0;
  logic [AW-1:0] p_addr = '0;

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (p_ce && !mem_ce_n) begin
        fall_cyc = cyc;
        chk(int'(mem_addr) == exp_addr[n_fall], "R2", "address at select",
            int'(mem_addr), exp_addr[n_fall]);
        if (have_rise) begin
          if (gap_exact)
            chk(cyc - rise_cyc == GAP_E + 1, "R7", "reselect gap", cyc - rise_cyc, GAP_E + 1);
          else
            chk(cyc - rise_cyc >= GAP_E + 1, "R7", "reselect gap min", cyc - rise_cyc, GAP_E + 1);
        end
        n_fall++;
      end else if (mem_addr != p_addr) begin
        chk(0, "R2", "address moved without select", int'(mem_addr), int'(p_addr));
      end
      if (!mem_ce_n && !p_ce && mem_addr != p_addr)
        chk(0, "R6", "address moved while selected", int'(mem_addr), int'(p_addr));
      if (p_oe && !mem_oe_n) begin
        chk(!mem_ce_n, "R3", "gate opened while deselected", mem_ce_n, 0);
        chk(cyc - fall_cyc == LEAD_E, "R4", "select to gate lead", cyc - fall_cyc, LEAD_E);
      end
      if (!mem_oe_n && mem_ce_n)
        chk(0, "R3", "gate low with select high", mem_oe_n, 1);
      if (rsp_valid) begin
        chk(cyc - fall_cyc == LEAD_E + OE_E, "R5", "sample edge", cyc - fall_cyc, LEAD_E + OE_E);
        chk(mem_ce_n && mem_oe_n, "R5", "strobes released with data",
            {mem_ce_n, mem_oe_n}, 3);
        chk(rsp_data == fpat(exp_addr[n_rsp]), "R9", "read data",
            rsp_data, fpat(exp_addr[n_rsp]));
        n_rsp++;
        rise_cyc  = cyc;
        have_rise = 1;
        if (p_rsp) chk(0, "R5", "valid longer than one cycle", 2, 1);
      end
      // memory model: true byte only if every access time is met by the next edge
      ce_age   = mem_ce_n ? 0 : ce_age + 1;
      oe_age   = mem_oe_n ? 0 : oe_age + 1;
      addr_age = (mem_addr != p_addr) ? 1 : addr_age + 1;
      if (!mem_ce_n && !mem_oe_n && ce_age * CLK_PS >= T_CE_NS * 1000 &&
          oe_age * CLK_PS >= T_OE_NS * 1000 && addr_age * CLK_PS >= T_CE_NS * 1000)
        mem_dq <= fpat(int'(mem_addr));
      else
        mem_dq <= ~fpat(int'(mem_addr));
      p_ce   = mem_ce_n;
      p_oe   = mem_oe_n;
      p_rsp  = rsp_valid;
      p_addr = mem_addr;
    end
  end

  task automatic send(input int a);
    exp_addr[n_sent] = a;
    n_sent++;
    req_valid = 1'b1;
    req_addr  = AW'(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    while (n_rsp < n_sent) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n == 1'b1, "R1", "select in reset", mem_ce_n, 1);
    chk(mem_oe_n == 1'b1, "R1", "gate in reset", mem_oe_n, 1);
    chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
    chk(rsp_valid == 1'b0, "R1", "valid in reset", rsp_valid, 0);

    // R1: request offered during the settle time must wait
    exp_addr[0] = 5;
    n_sent      = 1;
    req_valid   = 1'b1;
    req_addr    = AW'(5);
    rst_n       = 1'b1;
    mon_en      = 1;
    k = 0;
    while (!req_ready && k < PWR_E + 10) begin
      @(negedge clk);
      k++;
      if (!req_ready && !mem_ce_n) chk(0, "R1", "select during settle", k, PWR_E);
    end
    chk(k == PWR_E, "R1", "settle edges before ready", k, PWR_E);
    @(negedge clk);

    // R9/R7: full address sweep, back to back
    gap_exact = 1;
    for (int a = 0; a < (1 << AW); a++) send(a);
    req_valid = 1'b0;
    drain();

    // R8: long standby
    repeat (80) @(negedge clk);
    chk(mem_ce_n && mem_oe_n, "R8", "strobes in standby", {mem_ce_n, mem_oe_n}, 3);
    chk(req_ready == 1'b1, "R8", "ready in standby", req_ready, 1);
    chk(n_fall == n_sent, "R8", "no stray select", n_fall, n_sent);

    // late single request after standby
    gap_exact = 0;
    send(42);
    req_valid = 1'b0;
    req_addr  = AW'(17);     // not offered: must not reach the memory (R2)
    while (!rsp_valid) @(negedge clk);

    // R7: request arrives mid-float, with a changed address while not ready (R2)
    repeat (2) @(negedge clk);
    gap_exact = 1;
    send(21);
    send(63);
    req_valid = 1'b0;
    drain();
    repeat (GAP_E + 3) @(negedge clk);
    chk(n_rsp == n_sent, "R9", "responses returned", n_rsp, n_sent);
    chk(int'(mem_addr) == 63, "R2", "address after last read", int'(mem_addr), 63);

    summary();
    $finish;
  end

endmodule